// File: doc/BRIEF.md
# Predicated Packed-Lane Integer Multiplier

This unit multiplies two fixed-width vector operands lane by lane. A 2-bit size input splits the vector into lanes of 8, 16, 32 or 64 bits. The number of lanes is the vector width divided by the lane width. A per-byte predicate decides which lanes are computed. An active lane returns the low lane-width bits of the product of its two lane values. An inactive lane returns the matching lane of the first operand unchanged, so the unit merges rather than zeroes. Because only the low bits of each product are kept, signed and unsigned operands give the same result, and no signedness input exists.

One array of 8x8 byte partial products serves all four lane widths. The size input selects which partial products are summed together within a 64-bit block. Each lane is summed on its own, so no carry crosses a lane boundary. The operands, size and predicate are captured together on a valid/ready handshake. The result appears with an output valid after a latency of 1 to 3 cycles, set by a parameter. No condition flags are produced.

Top module: `lanewise_mul`

## Requirements
- R1: `size_i` selects the lane width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. The vector holds `VEC_W`/width lanes, and lane n occupies bits [n*width +: width].
- R2: An active lane outputs the low lane-width bits of the product of its `opa_i` and `opb_i` lane values. Upper product bits are discarded; for example, 0xFF times 0xFF in an 8-bit lane gives 0x01. No carry passes into a neighbouring lane.
- R3: An inactive lane outputs the matching lane of `opa_i` unchanged.
- R4: `pred_i` has one bit per byte, with bit k belonging to byte k. A lane is active exactly when the predicate bit of its lowest byte is 1. The other predicate bits of that lane are ignored.
- R5: When no lane is active, `res_o` equals `opa_i` whatever `opb_i` holds.
- R6: The inputs are captured on a clock edge where `in_valid_i` and `in_ready_o` are both high. With `out_ready_i` held high, `out_valid_o` rises after exactly `LAT` rising edges counted from that capture edge, and it is low on the edges before.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` and `res_o` hold their values and `in_ready_o` is low.
- R8: After reset, `out_valid_o` is low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input operands are valid |
| in_ready_o | output | 1 | Unit can accept an operation |
| size_i | input | 2 | Lane width select |
| pred_i | input | VEC_W/8 | Predicate, one bit per byte |
| opa_i | input | VEC_W | First operand and merge source |
| opb_i | input | VEC_W | Second operand |
| out_valid_o | output | 1 | Result is valid |
| out_ready_i | input | 1 | Consumer accepts the result |
| res_o | output | VEC_W | Result vector |

## Verification
A wrong lane grouping in the partial-product combine shows up as corrupted lane bytes on `res_o`. The corruption appears in the same transfer that reaches `out_valid_o` `LAT` cycles after capture, and it is clearest in the overflow and carry-boundary patterns of the wider lanes. A predicate read from the wrong byte flips a lane between product and merge, which the sparse predicates expose at once. Pipeline valid or stall faults show up as `out_valid_o` rising one edge early or late, or as `res_o` changing during a held stall.

// File: rtl/lmul_pkg.sv
package lmul_pkg;
  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2,
    LW_64 = 2'd3
  } lane_w_e;
endpackage

// File: rtl/lmul_block.sv
// one 64-bit block: 8x8 byte partial products, summed per lane
module lmul_block (
  input  logic [1:0]  size_i,
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  output logic [63:0] p_o
);
  localparam int NB = 8;

  logic [15:0] pp [NB][NB];
  logic [63:0] acc [NB];

  for (genvar i = 0; i < NB; i++) begin : g_row
    for (genvar j = 0; j < NB; j++) begin : g_col
      assign pp[i][j] = a_i[8*i +: 8] * b_i[8*j +: 8];
    end
  end

  always_comb begin
    for (int l = 0; l < NB; l++) acc[l] = '0;
    for (int i = 0; i < NB; i++) begin
      for (int j = 0; j < NB; j++) begin
        if ((i >> size_i) == (j >> size_i)) begin
          if (((i + j) - 2 * ((i >> size_i) << size_i)) < (1 << size_i)) begin
            acc[i >> size_i] = acc[i >> size_i]
              + (64'(pp[i][j]) << (8 * ((i + j) - 2 * ((i >> size_i) << size_i))));
          end
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      p_o[8*k +: 8] = acc[k >> size_i][8*(k - ((k >> size_i) << size_i)) +: 8];
    end
  end
endmodule

// File: rtl/lmul_merge.sv
// lane select: product where the lane's lowest predicate bit is set, else operand a
module lmul_merge #(
  parameter int NBYTE = 16
) (
  input  logic [1:0]         size_i,
  input  logic [NBYTE-1:0]   pred_i,
  input  logic [8*NBYTE-1:0] a_i,
  input  logic [8*NBYTE-1:0] prod_i,
  output logic [8*NBYTE-1:0] res_o
);
  always_comb begin
    for (int k = 0; k < NBYTE; k++) begin
      if (pred_i[(k >> size_i) << size_i]) res_o[8*k +: 8] = prod_i[8*k +: 8];
      else                                 res_o[8*k +: 8] = a_i[8*k +: 8];
    end
  end
endmodule

// File: rtl/lmul_pipe.sv
// result delay stages, all advancing together
module lmul_pipe #(
  parameter int W     = 128,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         v_i,
  input  logic [W-1:0] d_i,
  output logic         v_o,
  output logic [W-1:0] d_o
);
  if (DEPTH == 0) begin : g_bypass
    assign v_o = v_i;
    assign d_o = d_i;
  end else begin : g_stages
    logic         v_q [DEPTH];
    logic [W-1:0] d_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < DEPTH; s++) begin
          v_q[s] <= 1'b0;
          d_q[s] <= '0;
        end
      end else if (adv_i) begin
        v_q[0] <= v_i;
        d_q[0] <= d_i;
        for (int s = 1; s < DEPTH; s++) begin
          v_q[s] <= v_q[s-1];
          d_q[s] <= d_q[s-1];
        end
      end
    end
    assign v_o = v_q[DEPTH-1];
    assign d_o = d_q[DEPTH-1];
  end
endmodule

// File: rtl/lanewise_mul.sv
module lanewise_mul #(
  parameter int VEC_W = 128,
  parameter int LAT   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [1:0]         size_i,
  input  logic [VEC_W/8-1:0] pred_i,
  input  logic [VEC_W-1:0]   opa_i,
  input  logic [VEC_W-1:0]   opb_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [VEC_W-1:0]   res_o
);
  localparam int NBYTE = VEC_W / 8;
  localparam int NBLK  = VEC_W / 64;

  logic               adv;
  logic               v_q;
  logic [1:0]         size_q;
  logic [NBYTE-1:0]   pred_q;
  logic [VEC_W-1:0]   a_q, b_q, b_eff, prod_w, merged_w;
  logic               any_act;

  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      size_q <= '0;
      pred_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
    end else if (adv) begin
      v_q <= in_valid_i;
      if (in_valid_i) begin
        size_q <= size_i;
        pred_q <= pred_i;
        a_q    <= opa_i;
        b_q    <= opb_i;
      end
    end
  end

  // second operand forced to zero when no lane is active
  always_comb begin
    any_act = 1'b0;
    for (int k = 0; k < NBYTE; k++)
      if (((k >> size_q) << size_q) == k && pred_q[k]) any_act = 1'b1;
  end
  assign b_eff = any_act ? b_q : '0;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    lmul_block i_blk (
      .size_i (size_q),
      .a_i    (a_q[64*g +: 64]),
      .b_i    (b_eff[64*g +: 64]),
      .p_o    (prod_w[64*g +: 64])
    );
  end

  lmul_merge #(.NBYTE(NBYTE)) i_merge (
    .size_i (size_q),
    .pred_i (pred_q),
    .a_i    (a_q),
    .prod_i (prod_w),
    .res_o  (merged_w)
  );

  lmul_pipe #(.W(VEC_W), .DEPTH(LAT-1)) i_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .v_i    (v_q),
    .d_i    (merged_w),
    .v_o    (out_valid_o),
    .d_o    (res_o)
  );
endmodule

module lanewise_mul_chk #(
  parameter int VEC_W = 128
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_ready_o,
  input logic               out_valid_o,
  input logic               out_ready_i,
  input logic [VEC_W-1:0]   res_o,
  input logic               v_q,
  input logic [VEC_W/8-1:0] pred_q,
  input logic [VEC_W-1:0]   a_q,
  input logic [VEC_W-1:0]   merged_w
);
  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(res_o));
  // R7
  stall_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);
  // R8
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);
  // R5
  all_off_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q && pred_q == '0 |-> merged_w == a_q);
  // R3
  lane0_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q && !pred_q[0] |-> merged_w[7:0] == a_q[7:0]);
endmodule

bind lanewise_mul lanewise_mul_chk #(.VEC_W(VEC_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .res_o       (res_o),
  .v_q         (v_q),
  .pred_q      (pred_q),
  .a_q         (a_q),
  .merged_w    (merged_w)
);

// File: tb/test_lanewise_mul.sv
`timescale 1ns/1ps
module test_lanewise_mul;
  localparam int VEC_W = 128;
  localparam int LAT   = 2;
  localparam int NBYTE = VEC_W / 8;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               in_valid_i = 1'b0;
  logic               in_ready_o;
  logic [1:0]         size_i = '0;
  logic [NBYTE-1:0]   pred_i = '0;
  logic [VEC_W-1:0]   opa_i = '0, opb_i = '0;
  logic               out_valid_o;
  logic               out_ready_i = 1'b1;
  logic [VEC_W-1:0]   res_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  lanewise_mul #(.VEC_W(VEC_W), .LAT(LAT)) i_lanewise_mul (.*);

  function automatic logic [VEC_W-1:0] model(input logic [1:0] sz, input logic [NBYTE-1:0] p,
                                             input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
    logic [VEC_W-1:0] r;
    int ew;
    ew = 8 << sz;
    r = a;
    for (int l = 0; l < VEC_W / ew; l++) begin
      logic [63:0] x, y, m, pr;
      m  = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
      x  = 64'(a >> (l * ew)) & m;
      y  = 64'(b >> (l * ew)) & m;
      pr = (x * y) & m;
      if (p[l * ew / 8]) begin
        for (int t = 0; t < ew; t++) r[l * ew + t] = pr[t];
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one transfer with out_ready high; checks latency and result
  task automatic run_op(input string req, input logic [1:0] sz, input logic [NBYTE-1:0] p,
                        input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
    @(negedge clk_i);
    size_i = sz; pred_i = p; opa_i = a; opb_i = b; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    opb_i = ~b;
    for (int c = 1; c < LAT; c++) begin
      chk("R6 early valid", VEC_W'(out_valid_o), '0);
      @(negedge clk_i);
    end
    chk("R6 valid", VEC_W'(out_valid_o), VEC_W'(1));
    chk(req, res_o, model(sz, p, a, b));
  endtask

  function automatic logic [VEC_W-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic t_reset();
    chk("R8 out_valid", VEC_W'(out_valid_o), '0);
    chk("R8 in_ready", VEC_W'(in_ready_o), VEC_W'(1));
  endtask

  task automatic t_sizes();
    for (int s = 0; s < 4; s++) begin
      run_op("R1 R2 all-on", 2'(s), '1, rnd(), rnd());
      run_op("R2 R3 sparse", 2'(s), NBYTE'(16'hA5C3), rnd(), rnd());
      run_op("R4 random pred", 2'(s), NBYTE'($urandom), rnd(), rnd());
    end
  endtask

  task automatic t_overflow();
    run_op("R2 ff*ff 8b", 2'd0, '1, '1, '1);
    run_op("R2 ffff*ffff 16b", 2'd1, '1, '1, '1);
    run_op("R2 max 32b", 2'd2, '1, '1, '1);
    run_op("R2 max 64b", 2'd3, '1, '1, '1);
    run_op("R2 carry 16b", 2'd1, '1, {8{16'h00FF}}, {8{16'h0101}});
  endtask

  task automatic t_pred_group();
    // only non-lowest bits set in each 64-bit lane: both lanes inactive
    run_op("R4 upper bits ignored", 2'd3, NBYTE'(16'hFEFE), rnd(), rnd());
    // lowest byte of each 32-bit lane set only
    run_op("R4 lowest bit 32b", 2'd2, NBYTE'(16'h1111), rnd(), rnd());
  endtask

  task automatic t_none_active();
    logic [VEC_W-1:0] a;
    a = rnd();
    run_op("R5 no active lane", 2'd0, '0, a, rnd());
    chk("R5 equals opa", res_o, a);
  endtask

  task automatic t_stall();
    logic [VEC_W-1:0] a, b, held;
    a = rnd(); b = rnd();
    @(negedge clk_i);
    out_ready_i = 1'b0;
    size_i = 2'd1; pred_i = '1; opa_i = a; opb_i = b; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    repeat (LAT + 2) @(negedge clk_i);
    held = res_o;
    chk("R7 valid held", VEC_W'(out_valid_o), VEC_W'(1));
    chk("R7 in_ready low", VEC_W'(in_ready_o), '0);
    repeat (3) @(negedge clk_i);
    chk("R7 data held", res_o, held);
    chk("R7 data value", res_o, model(2'd1, '1, a, b));
    out_ready_i = 1'b1;
    @(negedge clk_i);
    chk("R7 drained", VEC_W'(out_valid_o), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_sizes();
    t_overflow();
    t_pred_group();
    t_none_active();
    t_stall();
    for (int n = 0; n < 40; n++)
      run_op("R2 R3 R4 random", 2'($urandom), NBYTE'($urandom), rnd(), rnd());
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule